// File: doc/BRIEF.md
# Multi-Lane Frame Start Aligner

This block watches the frame-start pulses of up to four incoming lanes and decides the single cycle in which every lane's read side may begin draining its elastic buffer. Each lane writes the first byte of a frame at buffer address zero. Reading should start once the latest lane has put enough data behind that first byte and the earliest lane has not yet drifted too far ahead. The block does this by placing the middle of the spread of arrivals at the half-full point of the buffers.

The first pulse from any enabled lane loads a counter with twice the half-buffer depth. While some enabled lane is still missing, the counter steps down by one each clock. In the clock where the last missing lane arrives, and in every clock after it, the counter steps down by two. When the counter reaches zero or goes below it, a one-cycle start strobe is produced and the block goes quiet. If the arrivals are spread too far apart, it raises a sticky error flag instead of the strobe. Lanes can be masked out. After the first alignment, only a software resync request arms the block again. The raw pulses pass through a two-stage synchronizer before the algorithm uses them.

Top module: `frame_align_sync`

## Requirements
- R1: After reset, `start_o` and `err_o` are low, and the block is armed and waiting for a first pulse.
- R2: When all enabled lanes pulse in the same clock, sampled by the rising edge n, `start_o` is high for the cycle that follows edge n+13. That is 2 synchronizer edges plus 12 counting edges at two per edge from 24.
- R3: The counter steps by one per clock while an enabled lane is still missing, and by two from the clock in which the last one arrives. Four lanes arriving on edges n..n+3 give `start_o` after edge n+15, which is 14 counting edges.
- R4: The strobe fires in the first counting edge where the counter would become zero or negative, so an odd remainder also fires. Two lanes on edges n and n+1 give `start_o` after edge n+14. `start_o` is never high for two consecutive cycles.
- R5: A lane whose bit in `lane_en_i` is 0 is ignored. Its pulses neither start counting nor count as an arrival. Lane i is bit i of `lane_pulse_i` and `lane_en_i`.
- R6: If an enabled lane is still missing 19 counting edges after the first arrival, `err_o` rises and stays high until a resync, and no strobe is issued. A spread of exactly 18 clocks is accepted: lanes on edges n and n+18 give `start_o` after edge n+22.
- R7: After the strobe, further pulses produce no strobe and no error until a resync.
- R8: A high `resync_i` sampled on an edge clears `err_o`, abandons any count in progress and re-arms the block. Pulses seen on that same edge are discarded.
- R9: Once aligned, enabling an extra lane and pulsing it does not disturb the result: no strobe and no error follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_pulse_i | input | 4 | Raw frame-start pulse per lane, one cycle wide |
| lane_en_i | input | 4 | Per-lane participation mask |
| resync_i | input | 1 | Software request to discard state and re-arm |
| start_o | output | 1 | One-cycle common start-of-read strobe |
| err_o | output | 1 | Sticky flag: arrivals too far apart to align |

## Verification
The embedded properties assume that each lane pulses at most once per alignment attempt. They also assume that `lane_en_i` holds still from the first arrival until the strobe or the error. Under those assumptions the counter falls monotonically and the arrival mask only grows. The stimulus changes the mask only while the block is armed, finished or faulted, and it issues one pulse per lane per attempt. The only exceptions are the deliberate post-alignment and mid-count resync cases, which the properties tolerate by design.

// File: rtl/align_pkg.sv
// Package: shared state encoding for the frame start aligner.
// Assumes: nothing; types only.
package align_pkg;
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_COUNT = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } align_state_e;
endpackage

// File: rtl/pulse_sync.sv
// Module: pulse_sync
// Carries each lane's raw pulse through a chain of STAGES flops into clk.
// Assumes: pulses are at least one clk cycle wide once they reach this domain.
module pulse_sync #(
    parameter int LANES  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] raw_i,
    output logic [LANES-1:0] sync_o
);
    logic [LANES-1:0] chain_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: shift one stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q[g] <= '0;
                end else if (g == 0) begin
                    chain_q[g] <= raw_i;
                end else begin
                    chain_q[g] <= chain_q[(g > 0) ? g-1 : 0];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/arrival_tracker.sv
// Module: arrival_tracker
// Remembers which enabled lanes have delivered a pulse in the current attempt.
// Assumes: track_i is high only while armed or counting; clear_i wins over track_i.
module arrival_tracker #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] pulse_i,
    input  logic [LANES-1:0] en_i,
    input  logic             track_i,
    input  logic             clear_i,
    output logic             any_new_o,
    output logic             all_prev_o,
    output logic             all_now_o
);
    logic [LANES-1:0] seen_q;
    logic [LANES-1:0] hit;
    logic [LANES-1:0] merged;

    // Purpose: qualify this cycle's pulses with the enable mask.
    always_comb begin
        hit        = pulse_i & en_i;
        merged     = seen_q | hit;
        any_new_o  = |hit;
        all_prev_o = ((seen_q & en_i) == en_i);
        all_now_o  = ((merged & en_i) == en_i);
    end

    // Purpose: accumulate arrivals; drop them on resync.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            seen_q <= '0;
        end else if (track_i) begin
            seen_q <= merged;
        end
    end

    // R7: the arrival mask only grows within an attempt
    a_r7_seen_grows: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((seen_q & $past(seen_q)) == $past(seen_q)));

    // R5: a lane that was disabled cannot newly enter the mask
    a_r5_masked_lane_silent: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((seen_q & ~$past(seen_q) & ~$past(en_i)) == '0));
endmodule

// File: rtl/align_ctrl.sv
// Module: align_ctrl
// Runs the two-speed down-counter, the skew limit check and the attempt state.
// Assumes: arrival flags come from arrival_tracker in the same cycle.
module align_ctrl
    import align_pkg::*;
#(
    parameter int HALF_DEPTH = 12,
    parameter int MAX_SKEW   = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         resync_i,
    input  logic         any_new_i,
    input  logic         all_prev_i,
    input  logic         all_now_i,
    output align_state_e state_o,
    output logic         start_o,
    output logic         err_o
);
    localparam int FULL = 2 * HALF_DEPTH;
    localparam int CW   = $clog2(FULL + 1) + 2;
    localparam int EW   = $clog2(MAX_SKEW + 2) + 1;
    localparam logic signed [CW-1:0] FULL_V = CW'(FULL);

    align_state_e           state_q;
    logic signed [CW-1:0]   cnt_q;
    logic signed [CW-1:0]   step_s;
    logic signed [CW-1:0]   cnt_nxt;
    logic        [EW-1:0]   elapsed_q;
    logic        [EW-1:0]   elapsed_nxt;
    logic                   too_wide;

    // Purpose: choose the step and form next counter and skew age.
    always_comb begin
        step_s      = all_now_i ? CW'(2) : CW'(1);
        cnt_nxt     = ((state_q == ST_ARMED) ? FULL_V : cnt_q) - step_s;
        elapsed_nxt = elapsed_q + EW'(1);
        too_wide    = !all_prev_i && (elapsed_nxt > EW'(MAX_SKEW));
    end

    // Purpose: sequence armed -> counting -> done/fault, with resync override.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_ARMED;
            cnt_q     <= '0;
            elapsed_q <= '0;
            start_o   <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            start_o <= 1'b0;
            if (resync_i) begin
                state_q   <= ST_ARMED;
                err_o     <= 1'b0;
                elapsed_q <= '0;
            end else begin
                unique case (state_q)
                    ST_ARMED: begin
                        if (any_new_i) begin
                            elapsed_q <= '0;
                            cnt_q     <= cnt_nxt;
                            if (cnt_nxt <= 0) begin
                                state_q <= ST_DONE;
                                start_o <= 1'b1;
                            end else begin
                                state_q <= ST_COUNT;
                            end
                        end
                    end
                    ST_COUNT: begin
                        elapsed_q <= elapsed_nxt;
                        if (too_wide) begin
                            state_q <= ST_FAULT;
                            err_o   <= 1'b1;
                        end else begin
                            cnt_q <= cnt_nxt;
                            if (cnt_nxt <= 0) begin
                                state_q <= ST_DONE;
                                start_o <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign state_o = state_q;

    // R3: counter falls on every counting cycle
    a_r3_count_descends: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && $past(state_q) == ST_COUNT) |-> (cnt_q < $past(cnt_q)));

    // R4: strobe lasts one cycle
    a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    // R6: error persists until resync
    a_r6_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !resync_i) |=> err_o);

    // R6: error and strobe never coincide
    a_r6_err_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !start_o);

    // R7: finished attempt stays quiet
    a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !resync_i) |=> !start_o);

    // R8: resync re-arms and clears flags
    a_r8_resync_rearms: assert property (@(posedge clk) disable iff (!rst_n)
        resync_i |=> (!err_o && !start_o && state_q == ST_ARMED));
endmodule

// File: rtl/frame_align_sync.sv
// Module: frame_align_sync (top)
// Synchronizes lane frame pulses and emits a common start-of-read strobe
// centred on the arrival spread, or an error when the spread is too wide.
// Assumes: one pulse per lane per attempt; mask steady while counting.
module frame_align_sync
    import align_pkg::*;
#(
    parameter int LANES       = 4,
    parameter int HALF_DEPTH  = 12,
    parameter int MAX_SKEW    = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] lane_pulse_i,
    input  logic [LANES-1:0] lane_en_i,
    input  logic             resync_i,
    output logic             start_o,
    output logic             err_o
);
    logic [LANES-1:0] pulse_s;
    logic             any_new;
    logic             all_prev;
    logic             all_now;
    logic             tracking;
    align_state_e     state;

    pulse_sync #(.LANES(LANES), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (lane_pulse_i),
        .sync_o (pulse_s)
    );

    // Purpose: record arrivals only while an attempt is open.
    assign tracking = (state == ST_ARMED) || (state == ST_COUNT);

    arrival_tracker #(.LANES(LANES)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_i    (pulse_s),
        .en_i       (lane_en_i),
        .track_i    (tracking),
        .clear_i    (resync_i),
        .any_new_o  (any_new),
        .all_prev_o (all_prev),
        .all_now_o  (all_now)
    );

    align_ctrl #(.HALF_DEPTH(HALF_DEPTH), .MAX_SKEW(MAX_SKEW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .resync_i   (resync_i),
        .any_new_i  (any_new),
        .all_prev_i (all_prev),
        .all_now_i  (all_now),
        .state_o    (state),
        .start_o    (start_o),
        .err_o      (err_o)
    );
endmodule

// File: tb/test_frame_align_sync.sv
module test_frame_align_sync;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] raw = '0;
    logic [3:0] en = '0;
    logic       resync = 1'b0;
    logic       start_o, err_o;

    int    checks = 0, fails = 0, cyc = 0;
    int    n_starts = 0, last_start = -1, P = 0;
    bit    finished = 0;
    string cur_req = "R1";

    frame_align_sync i_frame_align_sync (
        .clk(clk), .rst_n(rst_n), .lane_pulse_i(raw), .lane_en_i(en),
        .resync_i(resync), .start_o(start_o), .err_o(err_o));

    always #10 clk = ~clk;

    // behavioural reference model
    bit [3:0] dq[$];
    int ph = 0, remain = 0, el = 0;
    bit [3:0] seen = '0;
    bit m_start = 0, m_err = 0;

    always @(posedge clk) begin
        bit [3:0] s;
        bit allp, alln;
        cyc++;
        if (!rst_n) begin
            dq = '{4'd0, 4'd0}; ph = 0; seen = '0; m_start = 0; m_err = 0;
        end else begin
            s = dq[0] & en;
            void'(dq.pop_front());
            dq.push_back(raw);
            m_start = 0;
            if (resync) begin
                ph = 0; seen = '0; m_err = 0;
            end else if (ph <= 1) begin
                allp = ((seen & en) == en);
                seen = seen | s;
                alln = ((seen & en) == en);
                if (ph == 0) begin
                    if (s != 0) begin
                        ph = 1; el = 0; remain = 24 - (alln ? 2 : 1);
                    end
                end else begin
                    el++;
                    if (!allp && el > 18) begin
                        ph = 3; m_err = 1;
                    end else begin
                        remain -= (alln ? 2 : 1);
                        if (remain <= 0) begin ph = 2; m_start = 1; end
                    end
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            chk(start_o === m_start, {cur_req, " start_o vs model"}, int'(start_o), int'(m_start));
            chk(err_o === m_err, {cur_req, " err_o vs model"}, int'(err_o), int'(m_err));
            if (start_o === 1'b1) begin n_starts++; last_start = cyc; end
        end
    end

    task automatic do_resync();
        @(negedge clk); resync = 1'b1;
        @(negedge clk); resync = 1'b0;
    endtask

    task automatic send(input logic [3:0] m);
        @(negedge clk); raw = m; P = cyc + 1;
        @(negedge clk); raw = '0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(start_o == 0 && err_o == 0, "R1 reset outputs", int'({start_o, err_o}), 0);

        // R2: aligned arrival
        cur_req = "R2"; en = 4'hF; n_starts = 0;
        send(4'hF); settle(30);
        chk(n_starts == 1, "R2 strobe count", n_starts, 1);
        chk(last_start == P + 13, "R2 strobe cycle", last_start, P + 13);

        // R7: pulses after done
        cur_req = "R7"; n_starts = 0;
        send(4'hF); send(4'h3); settle(40);
        chk(n_starts == 0 && err_o == 0, "R7 quiet after done", n_starts, 0);

        // R3: spread over four clocks
        cur_req = "R3"; do_resync(); n_starts = 0;
        @(negedge clk); raw = 4'h1; P = cyc + 1;
        @(negedge clk); raw = 4'h2;
        @(negedge clk); raw = 4'h4;
        @(negedge clk); raw = 4'h8;
        @(negedge clk); raw = 4'h0;
        settle(30);
        chk(last_start == P + 15, "R3 strobe cycle", last_start, P + 15);

        // R5: disabled lanes ignored
        cur_req = "R5"; do_resync(); en = 4'h5; n_starts = 0;
        send(4'hA); settle(40);
        chk(n_starts == 0 && err_o == 0, "R5 disabled pulses ignored", n_starts, 0);
        send(4'h5); settle(30);
        chk(last_start == P + 13, "R5 enabled subset aligned", last_start, P + 13);

        // R4: odd remainder fires at zero or below
        cur_req = "R4"; do_resync(); en = 4'h3; n_starts = 0;
        @(negedge clk); raw = 4'h1; P = cyc + 1;
        @(negedge clk); raw = 4'h2;
        @(negedge clk); raw = 4'h0;
        settle(30);
        chk(last_start == P + 14, "R4 odd remainder cycle", last_start, P + 14);
        chk(n_starts == 1, "R4 single strobe", n_starts, 1);

        // R6: spread of 18 accepted
        cur_req = "R6"; do_resync(); n_starts = 0;
        send(4'h1); repeat (16) @(negedge clk);
        @(negedge clk); raw = 4'h2; chk(cyc + 1 == P + 18, "R6 stimulus spacing", cyc + 1, P + 18);
        @(negedge clk); raw = 4'h0;
        settle(30);
        chk(last_start == P + 22 && err_o == 0, "R6 spread 18 accepted", last_start, P + 22);

        // R6: spread of 19 rejected
        do_resync(); n_starts = 0;
        send(4'h1); repeat (17) @(negedge clk);
        @(negedge clk); raw = 4'h2;
        @(negedge clk); raw = 4'h0;
        settle(30);
        chk(err_o == 1, "R6 spread 19 error", int'(err_o), 1);
        chk(n_starts == 0, "R6 no strobe on error", n_starts, 0);

        // R8: resync clears error and aborts a running count
        cur_req = "R8"; do_resync(); #1;
        chk(err_o == 0, "R8 error cleared", int'(err_o), 0);
        en = 4'hF; n_starts = 0;
        send(4'hF); settle(4); do_resync(); settle(40);
        chk(n_starts == 0, "R8 count abandoned", n_starts, 0);
        send(4'hF); settle(30);
        chk(last_start == P + 13, "R8 re-armed alignment", last_start, P + 13);

        // R9: late lane enable after alignment
        cur_req = "R9"; do_resync(); en = 4'h3; n_starts = 0;
        send(4'h3); settle(30);
        chk(n_starts == 1, "R9 first alignment", n_starts, 1);
        en = 4'hF; n_starts = 0;
        send(4'hC); send(4'hF); settle(40);
        chk(n_starts == 0 && err_o == 0, "R9 late enable no effect", n_starts, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule